// File: doc/BRIEF.md
# Palette DAC Host Register Unlock Sequencer

This block is the CPU-facing byte register interface of a palette DAC. The CPU reads and writes single bytes on a small port space: an address-write port, a pixel-mask port and further palette ports that this block does not decode. Normally, the pixel-mask port reaches a plain 8-bit pixel mask register. A command register and a bank of extended registers sit behind that port. Software reaches them only by a counted run of pixel-mask reads.

Once that run has been made, the next pixel-mask access reads or writes the command register. If the command register's indexed-mode bit is set when that access completes, the next two pixel-mask writes load a 16-bit index, low byte first. After that, every pixel-mask access reaches the extended register selected by the index, and the index steps up by one after each access. Any access to the address-write port ends all hidden access and starts the count again. The extended registers drive the mode, pipeline, soft-reset and power control outputs. The command register drives the 2x8-bit pixel port mode output.

Top module: `pdac_host_regs`

## Requirements
- R1: After synchronous reset, the outputs take these values: pixel mask 0xFF, command register 0x00 (mode output 0), pipeline register 0x02, and the other mode, reset and power registers 0x00. The unlock count starts from zero, so one pixel-mask read returns the pixel mask.
- R2: Four consecutive pixel-mask reads arm the unlock. The next pixel-mask access, read or write, reaches the command register. The pixel mask is left unchanged.
- R3: An access of either kind to the address-write port (acc_port = 0) clears the read count. It also ends any armed, index-loading or indexed state.
- R4: During the read run, a pixel-mask write or an access to another port (acc_port = 2 or 3) sets the count back to zero without arming. A pixel-mask write still updates the pixel mask.
- R5: When command bit 4 (mask 0x10) is set after the command access, the next two pixel-mask writes load the index. The first write loads bits 7:0 and the second loads bits 15:8.
- R6: Once the index is loaded, each pixel-mask read or write reaches the extended register selected by the index. The index then steps up by one, wrapping from 0xFFFF to 0x0000.
- R7: Extended register 0 reads 0x44 and register 1 reads 0x02. Register 2 reads 0x00. All three ignore writes.
- R8: Extended registers 3 to 7 can be read and written. They drive primary_mode, secondary_mode, pipe_timing, soft_reset and power_ctrl, in that order.
- R9: Extended index values 0x08 and above read 0x00. Writes to them change no register.
- R10: Command bit 3 (mask 0x08) is driven on pix2x8_mode.
- R11: If command bit 4 is clear after the command access, later pixel-mask accesses reach the pixel mask again, and a new count starts from zero.
- R12: A pixel-mask read while the index is being loaded returns the pixel mask. It abandons the index load and returns to plain pixel-mask access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | One byte access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | 0 address-write, 1 pixel-mask, 2 and 3 other ports |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the presented read, same cycle; 0 when not decoded |
| pixel_mask | output | 8 | Plain pixel mask register |
| pix2x8_mode | output | 1 | 2x8-bit pixel port mode (command bit 3) |
| primary_mode | output | 8 | Extended register 3 |
| secondary_mode | output | 8 | Extended register 4 |
| pipe_timing | output | 8 | Extended register 5 |
| soft_reset | output | 8 | Extended register 6 |
| power_ctrl | output | 8 | Extended register 7 |

## Verification
The assertions check the following on every cycle. An address-write access clears the sequencer. A pixel-mask write or a foreign-port access breaks a partial run. Arming happens only on a pixel-mask read, and a command access leaves the pixel mask alone. The index steps after each extended access, the identity byte reads back correctly, and writes above the populated range are dropped. The mode output follows command writes.

Only the bench scenarios can show the ordering effects as seen by software. These are that the fifth read returns the command register rather than the mask, and that the index loads low byte first. They also cover the full read-back of every extended register, the wrap of the index at 0xFFFF, a read that abandons the index load, and reset taken during an armed run.

// File: rtl/pdac_host_pkg.sv
package pdac_host_pkg;

  typedef enum logic [2:0] {
    SQ_COUNT   = 3'd0,
    SQ_ARMED   = 3'd1,
    SQ_IDX_LO  = 3'd2,
    SQ_IDX_HI  = 3'd3,
    SQ_INDEXED = 3'd4
  } seq_state_e;

  localparam logic [1:0] PORT_ADDR_WR  = 2'd0;
  localparam logic [1:0] PORT_PIX_MASK = 2'd1;

  localparam logic [7:0] ID_MAKER  = 8'h44;
  localparam logic [7:0] ID_DEVICE = 8'h02;
  localparam logic [7:0] MASK_RESET = 8'hFF;
  localparam logic [7:0] CMD_RESET  = 8'h00;

  localparam int CMD_IDX_BIT  = 4;
  localparam int CMD_2X8_BIT  = 3;
  localparam int FIRST_RW_SLOT = 3;
  localparam int PIPE_SLOT     = 5;

  function automatic logic [7:0] ext_reset_value(input int slot);
    return (slot == PIPE_SLOT) ? 8'h02 : 8'h00;
  endfunction

  function automatic logic [15:0] index_bump(input logic [15:0] idx);
    return idx + 16'd1;
  endfunction

  function automatic logic cmd_index_on(input logic [7:0] cmd);
    return cmd[CMD_IDX_BIT];
  endfunction

endpackage

// File: rtl/pdac_unlock_seq.sv
module pdac_unlock_seq
  import pdac_host_pkg::*;
#(
  parameter int UNLOCK_READS = 4,
  localparam int CW = (UNLOCK_READS > 1) ? $clog2(UNLOCK_READS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_port,
  input  logic          idx_mode_next,
  output seq_state_e    state,
  output logic [CW-1:0] run_cnt,
  output logic          hit_mask,
  output logic          hit_cmd,
  output logic          hit_idx_lo,
  output logic          hit_idx_hi,
  output logic          hit_ext
);

  localparam logic [CW-1:0] LAST_CNT = CW'(UNLOCK_READS - 1);

  logic is_addr, is_pm, is_other;
  seq_state_e    state_d;
  logic [CW-1:0] cnt_d;

  assign is_addr  = acc_valid && (acc_port == PORT_ADDR_WR);
  assign is_pm    = acc_valid && (acc_port == PORT_PIX_MASK);
  assign is_other = acc_valid && !is_addr && !is_pm;

  assign hit_cmd    = is_pm && (state == SQ_ARMED);
  assign hit_idx_lo = is_pm && acc_write && (state == SQ_IDX_LO);
  assign hit_idx_hi = is_pm && acc_write && (state == SQ_IDX_HI);
  assign hit_ext    = is_pm && (state == SQ_INDEXED);
  assign hit_mask   = is_pm && !hit_cmd && !hit_idx_lo && !hit_idx_hi && !hit_ext;

  always_comb begin
    state_d = state;
    cnt_d   = run_cnt;
    if (is_addr) begin
      state_d = SQ_COUNT;
      cnt_d   = '0;
    end else begin
      unique case (state)
        SQ_COUNT: begin
          if (is_pm && !acc_write) begin
            if (run_cnt == LAST_CNT) begin
              state_d = SQ_ARMED;
              cnt_d   = '0;
            end else begin
              cnt_d = run_cnt + 1'b1;
            end
          end else if (is_pm || is_other) begin
            cnt_d = '0;
          end
        end
        SQ_ARMED: begin
          if (is_pm)         state_d = idx_mode_next ? SQ_IDX_LO : SQ_COUNT;
          else if (is_other) state_d = SQ_COUNT;
        end
        SQ_IDX_LO: begin
          if (is_pm) state_d = acc_write ? SQ_IDX_HI : SQ_COUNT;
        end
        SQ_IDX_HI: begin
          if (is_pm) state_d = acc_write ? SQ_INDEXED : SQ_COUNT;
        end
        SQ_INDEXED: state_d = SQ_INDEXED;
        default: begin
          state_d = SQ_COUNT;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_COUNT;
      run_cnt <= '0;
    end else begin
      state   <= state_d;
      run_cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/pdac_index_ptr.sv
module pdac_index_ptr
  import pdac_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16,
  localparam int HIW = IW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_lo,
  input  logic          load_hi,
  input  logic          step,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] index
);

  always_ff @(posedge clk) begin
    if (rst) begin
      index <= '0;
    end else if (load_lo) begin
      index[DW-1:0] <= wdata;
    end else if (load_hi) begin
      index[IW-1:DW] <= wdata[HIW-1:0];
    end else if (step) begin
      index <= IW'(index_bump(16'(index)));
    end
  end

endmodule

// File: rtl/pdac_plain_regs.sv
module pdac_plain_regs
  import pdac_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_mask,
  input  logic          hit_cmd,
  input  logic          acc_write,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] cmd_q,
  output logic          idx_mode_next
);

  logic [DW-1:0] cmd_after;

  assign cmd_after     = (hit_cmd && acc_write) ? wdata : cmd_q;
  assign idx_mode_next = cmd_index_on(8'(cmd_after));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= DW'(MASK_RESET);
      cmd_q  <= DW'(CMD_RESET);
    end else begin
      if (hit_mask && acc_write) mask_q <= wdata;
      if (hit_cmd && acc_write)  cmd_q  <= wdata;
    end
  end

endmodule

// File: rtl/pdac_ext_regfile.sv
module pdac_ext_regfile
  import pdac_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int NUM_EXT = 8,
  localparam int SW = $clog2(NUM_EXT)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hit_ext,
  input  logic                        acc_write,
  input  logic [IW-1:0]               index,
  input  logic [DW-1:0]               wdata,
  output logic [NUM_EXT-1:0][DW-1:0]  slot_q,
  output logic [DW-1:0]               rd_val
);

  logic in_range;
  logic wr_en;

  assign in_range = (index < IW'(NUM_EXT));
  assign wr_en    = hit_ext && acc_write && in_range;

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_slot
    if (g == 0) begin : g_maker
      assign slot_q[g] = DW'(ID_MAKER);
    end else if (g == 1) begin : g_device
      assign slot_q[g] = DW'(ID_DEVICE);
    end else if (g < FIRST_RW_SLOT) begin : g_reserved
      assign slot_q[g] = '0;
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                 q <= DW'(ext_reset_value(g));
        else if (wr_en && index == IW'(g))       q <= wdata;
      end
      assign slot_q[g] = q;
    end
  end

  assign rd_val = in_range ? slot_q[index[SW-1:0]] : '0;

endmodule

// File: rtl/pdac_host_regs.sv
module pdac_host_regs
  import pdac_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int NUM_EXT = 8,
  parameter int UNLOCK_READS = 4,
  localparam int CW = (UNLOCK_READS > 1) ? $clog2(UNLOCK_READS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_port,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] pixel_mask,
  output logic          pix2x8_mode,
  output logic [DW-1:0] primary_mode,
  output logic [DW-1:0] secondary_mode,
  output logic [DW-1:0] pipe_timing,
  output logic [DW-1:0] soft_reset,
  output logic [DW-1:0] power_ctrl
);

  seq_state_e           seq_state;
  logic [CW-1:0]        run_cnt;
  logic                 hit_mask, hit_cmd, hit_idx_lo, hit_idx_hi, hit_ext;
  logic                 idx_mode_next;
  logic [DW-1:0]        cmd_q;
  logic [IW-1:0]        ext_index;
  logic [NUM_EXT-1:0][DW-1:0] slot_q;
  logic [DW-1:0]        ext_rd;

  pdac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS)) i_seq (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .idx_mode_next(idx_mode_next), .state(seq_state),
    .run_cnt(run_cnt), .hit_mask(hit_mask), .hit_cmd(hit_cmd),
    .hit_idx_lo(hit_idx_lo), .hit_idx_hi(hit_idx_hi), .hit_ext(hit_ext)
  );

  pdac_plain_regs #(.DW(DW)) i_plain (
    .clk(clk), .rst(rst), .hit_mask(hit_mask), .hit_cmd(hit_cmd),
    .acc_write(acc_write), .wdata(wdata), .mask_q(pixel_mask),
    .cmd_q(cmd_q), .idx_mode_next(idx_mode_next)
  );

  pdac_index_ptr #(.DW(DW), .IW(IW)) i_index (
    .clk(clk), .rst(rst), .load_lo(hit_idx_lo), .load_hi(hit_idx_hi),
    .step(hit_ext), .wdata(wdata), .index(ext_index)
  );

  pdac_ext_regfile #(.DW(DW), .IW(IW), .NUM_EXT(NUM_EXT)) i_ext (
    .clk(clk), .rst(rst), .hit_ext(hit_ext), .acc_write(acc_write),
    .index(ext_index), .wdata(wdata), .slot_q(slot_q), .rd_val(ext_rd)
  );

  always_comb begin
    rdata = '0;
    if (acc_valid && !acc_write) begin
      if (hit_mask)     rdata = pixel_mask;
      else if (hit_cmd) rdata = cmd_q;
      else if (hit_ext) rdata = ext_rd;
    end
  end

  assign pix2x8_mode    = cmd_q[CMD_2X8_BIT];
  assign primary_mode   = slot_q[3];
  assign secondary_mode = slot_q[4];
  assign pipe_timing    = slot_q[5];
  assign soft_reset     = slot_q[6];
  assign power_ctrl     = slot_q[7];

endmodule

// File: rtl/pdac_host_regs_chk.sv
module pdac_host_regs_chk
  import pdac_host_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 16,
  parameter int NUM_EXT = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [1:0]    acc_port,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input seq_state_e    seq_state,
  input logic [CW-1:0] run_cnt,
  input logic          hit_cmd,
  input logic          hit_ext,
  input logic [IW-1:0] ext_index,
  input logic [DW-1:0] pixel_mask,
  input logic          pix2x8_mode,
  input logic [DW-1:0] primary_mode,
  input logic [DW-1:0] secondary_mode,
  input logic [DW-1:0] pipe_timing,
  input logic [DW-1:0] soft_reset,
  input logic [DW-1:0] power_ctrl
);

  assert_addr_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_port == PORT_ADDR_WR) |=> (seq_state == SQ_COUNT && run_cnt == '0));

  assert_break_run_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && seq_state == SQ_COUNT &&
     (acc_port[1] || (acc_port == PORT_PIX_MASK && acc_write)))
    |=> (seq_state == SQ_COUNT && run_cnt == '0));

  assert_arm_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_state == SQ_ARMED) |-> $past(acc_valid && acc_port == PORT_PIX_MASK && !acc_write));

  assert_cmd_keeps_mask_R2: assert property (@(posedge clk) disable iff (rst)
    hit_cmd |=> $stable(pixel_mask));

  assert_index_step_R6: assert property (@(posedge clk) disable iff (rst)
    hit_ext |=> (ext_index == IW'($past(ext_index) + 1'b1)));

  assert_maker_id_R7: assert property (@(posedge clk) disable iff (rst)
    (hit_ext && !acc_write && ext_index == '0) |-> (rdata == 8'h44));

  assert_slot3_write_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_ext && acc_write && ext_index == IW'(3)) |=> (primary_mode == $past(wdata)));

  assert_high_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_ext && acc_write && ext_index >= IW'(NUM_EXT))
    |=> $stable({primary_mode, secondary_mode, pipe_timing, soft_reset, power_ctrl, pixel_mask}));

  assert_mode_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (hit_cmd && acc_write) |=> (pix2x8_mode == $past(wdata[CMD_2X8_BIT])));

  assert_revert_R11: assert property (@(posedge clk) disable iff (rst)
    (hit_cmd && acc_write && !wdata[CMD_IDX_BIT]) |=> (seq_state == SQ_COUNT));

endmodule

bind pdac_host_regs pdac_host_regs_chk #(.DW(DW), .IW(IW), .NUM_EXT(NUM_EXT), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_port(acc_port), .wdata(wdata), .rdata(rdata), .seq_state(seq_state),
  .run_cnt(run_cnt), .hit_cmd(hit_cmd), .hit_ext(hit_ext), .ext_index(ext_index),
  .pixel_mask(pixel_mask), .pix2x8_mode(pix2x8_mode), .primary_mode(primary_mode),
  .secondary_mode(secondary_mode), .pipe_timing(pipe_timing),
  .soft_reset(soft_reset), .power_ctrl(power_ctrl)
);

// File: tb/test_pdac_host_regs.sv
module test_pdac_host_regs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [1:0] acc_port = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pixel_mask, primary_mode, secondary_mode, pipe_timing, soft_reset, power_ctrl;
  logic       pix2x8_mode;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pdac_host_regs i_pdac_host_regs (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_port(acc_port), .wdata(wdata), .rdata(rdata), .pixel_mask(pixel_mask),
    .pix2x8_mode(pix2x8_mode), .primary_mode(primary_mode),
    .secondary_mode(secondary_mode), .pipe_timing(pipe_timing),
    .soft_reset(soft_reset), .power_ctrl(power_ctrl)
  );

  // port: 0 address-write, 1 pixel-mask, 2 other
  typedef struct packed {
    logic [1:0] port;
    logic       wr;
    logic [7:0] data;
    logic       chk;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 58;
  localparam vec_t VT [0:NV-1] = '{
    '{2'd1,1'b0,8'h00,1'b1,8'hFF,4'd1},  // R1 mask reset value
    '{2'd1,1'b0,8'h00,1'b1,8'hFF,4'd1},
    '{2'd1,1'b0,8'h00,1'b1,8'hFF,4'd1},
    '{2'd1,1'b1,8'h5A,1'b0,8'h00,4'd4},  // R4 write breaks run
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd0,1'b1,8'h00,1'b0,8'h00,4'd3},  // R3 address write clears
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd2,1'b0,8'h00,1'b0,8'h00,4'd4},  // R4 other port breaks run
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd4},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd2},
    '{2'd1,1'b0,8'h00,1'b1,8'h00,4'd2},  // R2 fifth read is command (reset 0)
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd11}, // R11 back to mask
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd11},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd11},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd11},
    '{2'd1,1'b1,8'h18,1'b0,8'h00,4'd2},  // R2 command write 0x18
    '{2'd1,1'b1,8'h03,1'b0,8'h00,4'd5},  // R5 index low
    '{2'd1,1'b1,8'h00,1'b0,8'h00,4'd5},  // R5 index high
    '{2'd1,1'b1,8'h11,1'b0,8'h00,4'd8},
    '{2'd1,1'b1,8'h22,1'b0,8'h00,4'd8},
    '{2'd1,1'b1,8'h07,1'b0,8'h00,4'd8},
    '{2'd1,1'b1,8'h01,1'b0,8'h00,4'd8},
    '{2'd1,1'b1,8'h33,1'b0,8'h00,4'd8},
    '{2'd1,1'b1,8'hEE,1'b0,8'h00,4'd9},  // R9 write at 0x08
    '{2'd1,1'b0,8'h00,1'b1,8'h00,4'd9},  // R9 read at 0x09
    '{2'd0,1'b1,8'h00,1'b0,8'h00,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h18,4'd2},
    '{2'd1,1'b1,8'h00,1'b0,8'h00,4'd5},
    '{2'd1,1'b1,8'h00,1'b0,8'h00,4'd5},
    '{2'd1,1'b1,8'h99,1'b0,8'h00,4'd7},  // R7 write to ID ignored
    '{2'd1,1'b0,8'h00,1'b1,8'h02,4'd7},
    '{2'd1,1'b0,8'h00,1'b1,8'h00,4'd7},
    '{2'd1,1'b0,8'h00,1'b1,8'h11,4'd6},  // R6 increment read-back
    '{2'd1,1'b0,8'h00,1'b1,8'h22,4'd6},
    '{2'd1,1'b0,8'h00,1'b1,8'h07,4'd8},
    '{2'd1,1'b0,8'h00,1'b1,8'h01,4'd8},
    '{2'd1,1'b0,8'h00,1'b1,8'h33,4'd8},
    '{2'd1,1'b0,8'h00,1'b1,8'h00,4'd9},
    '{2'd0,1'b0,8'h00,1'b0,8'h00,4'd3},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd2},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd2},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd2},
    '{2'd1,1'b0,8'h00,1'b1,8'h5A,4'd2},
    '{2'd1,1'b0,8'h00,1'b1,8'h18,4'd2},
    '{2'd1,1'b1,8'h00,1'b0,8'h00,4'd5},
    '{2'd1,1'b1,8'h00,1'b0,8'h00,4'd5},
    '{2'd1,1'b0,8'h00,1'b1,8'h44,4'd7},  // R7 maker byte, write ignored
    '{2'd0,1'b1,8'h00,1'b0,8'h00,4'd3}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] port, input logic wr, input logic [7:0] d,
                     output logic [7:0] rd);
    @(negedge clk);
    acc_valid = 1'b1; acc_port = port; acc_write = wr; wdata = d;
    #1 rd = rdata;
    @(posedge clk);
    #1 acc_valid = 1'b0; acc_write = 1'b0; wdata = 8'h00;
  endtask

  task automatic pm_read_exp(input string tag, input logic [7:0] exp);
    logic [7:0] r;
    acc(2'd1, 1'b0, 8'h00, r);
    check(tag, r, exp);
  endtask

  task automatic pm_write(input logic [7:0] d);
    logic [7:0] r;
    acc(2'd1, 1'b1, d, r);
  endtask

  task automatic addr_touch();
    logic [7:0] r;
    acc(2'd0, 1'b1, 8'h00, r);
  endtask

  task automatic unlock(input logic [7:0] mask_exp);
    for (int k = 0; k < 4; k++) pm_read_exp("R2 unlock read", mask_exp);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 pipe_timing reset", pipe_timing, 8'h02);
    check("R1 pixel_mask reset", pixel_mask, 8'hFF);
    check("R10 mode reset", {7'd0, pix2x8_mode}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      acc(VT[v].port, VT[v].wr, VT[v].data, r);
      if (VT[v].chk) check($sformatf("R%0d vector %0d", VT[v].req, v), r, VT[v].exp);
    end

    // R8 outputs and R10 mode output after the table
    check("R8 primary_mode", primary_mode, 8'h11);
    check("R8 secondary_mode", secondary_mode, 8'h22);
    check("R8 pipe_timing", pipe_timing, 8'h07);
    check("R8 soft_reset", soft_reset, 8'h01);
    check("R8 power_ctrl", power_ctrl, 8'h33);
    check("R9 pixel_mask untouched", pixel_mask, 8'h5A);
    check("R10 pix2x8 set", {7'd0, pix2x8_mode}, 8'h01);

    // R6 index wrap
    unlock(8'h5A);
    pm_read_exp("R2 command read", 8'h18);
    pm_write(8'hFF); pm_write(8'hFF);
    pm_read_exp("R6 index 0xFFFF", 8'h00);
    pm_read_exp("R6 wrapped to 0", 8'h44);
    addr_touch();

    // R12 read abandons the index load
    unlock(8'h5A);
    pm_read_exp("R2 command read", 8'h18);
    pm_read_exp("R12 read during load", 8'h5A);
    pm_write(8'h3C);
    check("R12 mask written after abandon", pixel_mask, 8'h3C);
    pm_read_exp("R12 plain mask read", 8'h3C);
    addr_touch();

    // R10 and R11 command write with indexed mode off
    unlock(8'h3C);
    pm_write(8'h00);
    check("R10 pix2x8 cleared", {7'd0, pix2x8_mode}, 8'h00);
    pm_read_exp("R11 mask after cmd", 8'h3C);
    addr_touch();

    // R1 reset while armed
    unlock(8'h3C);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check("R1 mask after reset", pixel_mask, 8'hFF);
    check("R1 pipe after reset", pipe_timing, 8'h02);
    check("R1 primary after reset", primary_mode, 8'h00);
    check("R1 power after reset", power_ctrl, 8'h00);
    pm_read_exp("R1 armed state cleared", 8'hFF);

    finish_run();
  end

endmodule